// File: doc/BRIEF.md
# Selectable-Event Monitor Counter

This block is a single free-running event counter placed next to a cache for performance measurement. A small configuration register chooses what the counter tallies: every clock cycle, every cycle that reports an instruction-fetch hit, or every cycle that reports a data-access hit. A separate enable flag starts and stops accumulation. A one-cycle clear command zeroes the tally without touching the configuration.

Software programs the source, sets the enable flag, optionally clears the count, and later reads the running value from the count output. Changing the source mid-run keeps the accumulated value, so several phases can be summed into one figure. The reset input is asserted asynchronously and released through a two-stage synchronizer inside the block.

Top module: `evmon_counter`

## Requirements
- R1: After reset the count is 0, counting is disabled and the selected source is clock cycles (code 0), so setting only the enable flag makes the count advance on every cycle.
- R2: With source code 0 and enable set, the count rises by exactly one on each clock edge.
- R3: With source code 1, the count rises by one on each edge where the instruction-hit strobe is high and ignores the data-hit strobe.
- R4: With source code 2, the count rises by one on each edge where the data-hit strobe is high and ignores the instruction-hit strobe.
- R5: Source code 3 is reserved: the count holds its value whatever the strobes do.
- R6: While the enable flag is clear the count holds its value, whatever the source and strobes.
- R7: A write to the source code or to the enable flag takes effect from the following cycle; an event in the cycle of the write is judged by the old setting.
- R8: A clear pulse makes the count read 0 after that edge, also when an event occurs in the same cycle; the clear lasts one cycle and counting resumes on the next edge.
- R9: Changing the source code does not alter the count.
- R10: The count wraps from all ones to 0 without saturating.
- R11: The count is CNT_W bits wide, 32 by default, and is visible on the count output after every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ihit_i | input | 1 | Instruction-fetch hit strobe, one per cycle |
| dhit_i | input | 1 | Data-access hit strobe, one per cycle |
| src_we_i | input | 1 | Write strobe for the source code |
| src_wdata_i | input | 2 | Source code: 0 cycles, 1 instruction hits, 2 data hits, 3 none |
| run_we_i | input | 1 | Write strobe for the enable flag |
| run_wdata_i | input | 1 | New enable flag value |
| clr_i | input | 1 | One-cycle clear command |
| count_o | output | CNT_W | Current count |

## Verification
The bench builds two copies side by side on the same stimulus: one with the default 32-bit width and one with CNT_W set to 8. The 8-bit copy reaches its all-ones value within a few hundred events, which brings the wrap-around of R10 within reach of a short random run, while the 32-bit copy confirms the full-width arithmetic and port width. Both are compared every cycle against one bench model, the narrow copy against the model value reduced modulo 256.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  localparam int unsigned SRC_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_CYCLES = 2'd0,
    SRC_IHIT   = 2'd1,
    SRC_DHIT   = 2'd2,
    SRC_NONE   = 2'd3
  } evsrc_e;

  localparam int unsigned NUM_SRC = 1 << SRC_W;

endpackage

// File: rtl/evmon_rst_sync.sv
module evmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/evmon_cfg.sv
module evmon_cfg
  import evmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_we,
  input  logic [SRC_W-1:0] src_wdata,
  input  logic             run_we,
  input  logic             run_wdata,
  output evsrc_e           src_q,
  output logic             run_q
);

  evsrc_e src_d;
  logic   run_d;

  always_comb begin
    src_d = src_q;
    if (src_we) src_d = evsrc_e'(src_wdata);
    run_d = run_q;
    if (run_we) run_d = run_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_CYCLES;
    else if (src_we) src_q <= src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (run_we) run_q <= run_d;
  end

  // R7: written values appear one edge after the strobe
  a_r7_src_load: assert property (@(posedge clk) disable iff (!rst_n)
    src_we |=> (src_q == evsrc_e'($past(src_wdata))));
  a_r7_run_load: assert property (@(posedge clk) disable iff (!rst_n)
    run_we |=> (run_q == $past(run_wdata)));
  a_r7_src_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !src_we |=> $stable(src_q));

endmodule

// File: rtl/evmon_src_sel.sv
module evmon_src_sel
  import evmon_pkg::*;
(
  input  evsrc_e src,
  input  logic   run,
  input  logic   ihit,
  input  logic   dhit,
  output logic   bump
);

  logic [NUM_SRC-1:0] src_vec;

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      case (evsrc_e'(k))
        SRC_CYCLES: src_vec[k] = 1'b1;
        SRC_IHIT:   src_vec[k] = ihit;
        SRC_DHIT:   src_vec[k] = dhit;
        default:    src_vec[k] = 1'b0;
      endcase
    end
  end

  assign bump = run & src_vec[src];

  // R5, R6: immediate checks on the select result
  always_comb begin
    if (src == SRC_NONE) a_r5_reserved_idle: assert (!bump || $isunknown(src));
    if (!run)            a_r6_off_idle:      assert (!bump || $isunknown(run));
  end

endmodule

// File: rtl/evmon_accum.sv
module evmon_accum #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = clr | bump;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R8: clear wins over a coincident event
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R6: no event, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bump) |=> $stable(cnt_q));
  // R2, R10: single step, modulo the width
  a_r10_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bump) |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/evmon_counter.sv
module evmon_counter
  import evmon_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ihit_i,
  input  logic             dhit_i,
  input  logic             src_we_i,
  input  logic [1:0]       src_wdata_i,
  input  logic             run_we_i,
  input  logic             run_wdata_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);

  logic   rst_sync_n;
  evsrc_e src_q;
  logic   run_q;
  logic   bump;

  evmon_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evmon_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_we    (src_we_i),
    .src_wdata (src_wdata_i),
    .run_we    (run_we_i),
    .run_wdata (run_wdata_i),
    .src_q     (src_q),
    .run_q     (run_q)
  );

  evmon_src_sel u_sel (
    .src  (src_q),
    .run  (run_q),
    .ihit (ihit_i),
    .dhit (dhit_i),
    .bump (bump)
  );

  evmon_accum #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .bump  (bump),
    .clr   (clr_i),
    .cnt_q (count_o)
  );

  // R9: a source write alone leaves the count untouched
  a_r9_src_keeps_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_we_i && !run_q && !clr_i) |=> $stable(count_o));
  // R3: in instruction-hit mode a quiet instruction strobe holds the count
  a_r3_ihit_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_q == SRC_IHIT && !ihit_i && !clr_i) |=> $stable(count_o));
  // R4: in data-hit mode a quiet data strobe holds the count
  a_r4_dhit_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_q == SRC_DHIT && !dhit_i && !clr_i) |=> $stable(count_o));

endmodule

// File: tb/evmon_counter_test.sv
module evmon_counter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ihit = 1'b0, dhit = 1'b0;
  logic        src_we = 1'b0, run_we = 1'b0, run_wd = 1'b0, clr = 1'b0;
  logic [1:0]  src_wd = 2'd0;
  logic [31:0] cnt_w;
  logic [7:0]  cnt_n;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit model_on = 1'b0;
  string tag = "R1";

  logic [31:0] exp_cnt = '0;
  logic [1:0]  m_src = 2'd0;
  logic        m_run = 1'b0;

  always #5 clk = ~clk;

  evmon_counter uut (
    .clk(clk), .rst_n(rst_n), .ihit_i(ihit), .dhit_i(dhit),
    .src_we_i(src_we), .src_wdata_i(src_wd), .run_we_i(run_we),
    .run_wdata_i(run_wd), .clr_i(clr), .count_o(cnt_w));

  evmon_counter #(.CNT_W(8)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .ihit_i(ihit), .dhit_i(dhit),
    .src_we_i(src_we), .src_wdata_i(src_wd), .run_we_i(run_we),
    .run_wdata_i(run_wd), .clr_i(clr), .count_o(cnt_n));

  function automatic bit counts(logic [1:0] s, logic r, logic ih, logic dh);
    if (!r) return 1'b0;
    case (s)
      2'd0: return 1'b1;
      2'd1: return ih;
      2'd2: return dh;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      if (clr) exp_cnt = '0;
      else if (counts(m_src, m_run, ihit, dhit)) exp_cnt = exp_cnt + 32'd1;
      if (src_we) m_src = src_wd;
      if (run_we) m_run = run_wd;
    end
  end

  task automatic check(string t, logic [31:0] got, logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, want, $time);
    end
  endtask

  task automatic compare();
    check(tag, cnt_w, exp_cnt);
    check("R10", {24'd0, cnt_n}, {24'd0, exp_cnt[7:0]});
  endtask

  task automatic step(bit ih, bit dh, bit swe, logic [1:0] swd, bit rwe, bit rwd, bit c);
    @(negedge clk);
    compare();
    ihit = ih; dhit = dh; src_we = swe; src_wd = swd;
    run_we = rwe; run_wd = rwd; clr = c;
  endtask

  task automatic idle(int n, bit ih, bit dh);
    for (int i = 0; i < n; i++) step(ih, dh, 0, 2'd0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_on = 1'b1;

    // R11: width and reset value
    check("R11", $bits(cnt_w), 32);
    // R1: idle after reset, strobes present but disabled
    tag = "R1";
    idle(4, 1, 1);
    // R7: enable write with events in the same cycle
    tag = "R7";
    step(1, 1, 0, 2'd0, 1, 1, 0);
    step(0, 0, 0, 2'd0, 0, 0, 0);
    // R1 default source is cycles; R2 steady increments
    tag = "R2";
    idle(10, 0, 0);
    // R9 source change keeps count; R3 instruction hits
    tag = "R9";
    step(0, 1, 1, 2'd1, 0, 0, 0);
    step(0, 1, 0, 2'd0, 0, 0, 0);
    tag = "R3";
    for (int i = 0; i < 12; i++) step(i % 3 == 0, i % 2 == 0, 0, 2'd0, 0, 0, 0);
    // R4 data hits
    tag = "R4";
    step(1, 1, 1, 2'd2, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(i % 2 == 0, i % 4 == 0, 0, 2'd0, 0, 0, 0);
    // R5 reserved code
    tag = "R5";
    step(1, 1, 1, 2'd3, 0, 0, 0);
    idle(6, 1, 1);
    // R6 disabled holds
    tag = "R6";
    step(1, 1, 1, 2'd0, 1, 0, 0);
    idle(6, 1, 1);
    // R8 clear with coincident event, then resume
    tag = "R8";
    step(0, 0, 0, 2'd0, 1, 1, 0);
    idle(3, 0, 0);
    step(1, 1, 0, 2'd0, 0, 0, 1);
    step(0, 0, 0, 2'd0, 0, 0, 0);
    idle(4, 0, 0);

    // random phase; tag follows the model's source code
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      s = m_src;
      case (s)
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = "R5";
      endcase
      if (!m_run) tag = "R6";
      step($urandom % 2 == 0, $urandom % 3 == 0,
           $urandom % 20 == 0, 2'($urandom % 4),
           $urandom % 25 == 0, $urandom % 5 != 0,
           $urandom % 300 == 0);
    end
    @(negedge clk);
    compare();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule